// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the memory-mapped front end of a simple UART. It sits on a 32-bit bus with byte addresses aligned to words and separate read and write strobes. It holds the line-format control word, the baud divisor word and the FIFO threshold settings. It drives those values out to the serial engines, which live outside the block along with the FIFO storage and the baud timing.

It also gathers live status from the engines into an interrupt/status register. That register has per-source enable masks and one sticky receive-overrun flag, and the block raises a single interrupt line from it. A single data port at its own offset does two jobs. A write pushes a character toward the transmit FIFO. A read returns the head receive character tagged with its error flags and pops it.

Software resets either FIFO by writing a control bit. The block turns that write into a one-cycle pulse, so the bit never reads back as set.

Top module: `uart_csr_block`

## Requirements
- R1: After reset, every stored field is zero, the FIFO reset pulses are low and `irq` is low.
- R2: The control word at offset 0x00 stores these fields, and reads return them:
  - receive timeout in [4:0]
  - stop-bit code in [11:8] (7 means one stop bit)
  - symbol-size code in [13:12] (3 means 8 data bits)
  - forced break in bit 14
  - receive parity: even-select in bit 16, enable in bit 17
  - transmit parity: even-select in bit 18, enable in bit 19
  - loopback in bit 20
  - receiver enable in bit 21, transmitter enable in bit 22, baud generator enable in bit 23

  Bits 6, 7, 15 and [31:24] always read as zero.
- R3: Writing the control word with bit 6 set pulses `rxFifoRst` high for exactly one cycle, starting the cycle after the write. Bit 7 does the same for `txFifoRst`.
- R4: The baud word at offset 0x04 stores all 32 bits, drives `baudWord` and reads back unchanged.
- R5: The FIFO config at offset 0x08 holds the receive threshold in [11:8] and the transmit threshold in [15:12]. Its other bits read as zero.
- R6: A write to the data port at offset 0x14 asserts `txPush` in the same cycle, with `txData` equal to write bits [7:0], unless `txFull` is high. In that case the write is dropped.
- R7: A read of the data port returns the receive character in bits [7:0], the frame error in bit 8, the parity error in bit 9 and the break flag in bit 10. It asserts `rxPop` for that cycle only when `rxNotEmpty` is high.
- R8: In the interrupt/status register at offset 0x10:
  - bit 5 mirrors `txEmpty`
  - bit 11 mirrors `rxNotEmpty`
  - bit 7 is set by an `rxOverrun` pulse and stays set until cleared
- R9: A write to offset 0x10 loads the enable masks from bits [31:16], and reads return them there. The write clears the overrun flag when its bit 7 is zero. An overrun pulse in the same cycle wins.
- R10: `irq` is high exactly when some status bit k in [15:0] is set together with enable bit 16+k.
- R11: Reads of unmapped offsets return zero, and writes to them change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the register |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| rxTimeout | output | 5 | Receive timeout value |
| stopCode | output | 4 | Stop-bit code |
| symSize | output | 2 | Symbol-size code |
| txBreak | output | 1 | Force a break on the line |
| rxParEven | output | 1 | Even receive parity |
| rxParEn | output | 1 | Receive parity enable |
| txParEven | output | 1 | Even transmit parity |
| txParEn | output | 1 | Transmit parity enable |
| loopback | output | 1 | Internal loopback |
| rxEnable | output | 1 | Receiver enable |
| txEnable | output | 1 | Transmitter enable |
| baudEnable | output | 1 | Baud generator enable |
| baudWord | output | 32 | Baud divisor word |
| rxThresh | output | 4 | Receive FIFO threshold |
| txThresh | output | 4 | Transmit FIFO threshold |
| rxFifoRst | output | 1 | One-cycle receive FIFO reset |
| txFifoRst | output | 1 | One-cycle transmit FIFO reset |
| txPush | output | 1 | Push a character into the transmit FIFO |
| txData | output | 8 | Character to push |
| rxPop | output | 1 | Pop the receive FIFO |
| txEmpty | input | 1 | Transmit FIFO is empty |
| txFull | input | 1 | Transmit FIFO is full |
| rxNotEmpty | input | 1 | Receive FIFO holds data |
| rxChar | input | 8 | Head receive character |
| rxFrameErr | input | 1 | Head character has a frame error |
| rxParErr | input | 1 | Head character has a parity error |
| rxBreak | input | 1 | Head entry is a break |
| rxOverrun | input | 1 | Receive overrun pulse |

## Verification
The assertions hold on every cycle for these behaviours:
- no push ever reaches a full transmit FIFO
- no pop ever reaches an empty receive FIFO
- each FIFO reset pulse lasts a single cycle
- an overrun pulse always leaves the sticky flag set, and it stays set until an interrupt-register write
- `irq` never rises without a live status source

The bench scenarios are needed for the exact bit positions seen on readback, the masking of the reserved and self-clearing bits, the tagging of receive errors, the write-zero clear, the per-source enables and the silence of unmapped offsets.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int OFF_CTL  = 'h00;
  localparam int OFF_BAUD = 'h04;
  localparam int OFF_CFG  = 'h08;
  localparam int OFF_IRQ  = 'h10;
  localparam int OFF_DATA = 'h14;

  // bit positions that software decodes
  localparam int CTL_RST_RX = 6;
  localparam int CTL_RST_TX = 7;
  localparam int ST_TXEMPTY = 5;
  localparam int ST_OVERRUN = 7;
  localparam int ST_RXAVAIL = 11;
  localparam int STAT_W     = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_BAUD, SEL_CFG, SEL_IRQ, SEL_DATA
  } regSel_e;

  typedef struct packed {
    logic    wrCtl;
    logic    wrBaud;
    logic    wrCfg;
    logic    wrIrq;
    logic    wrData;
    logic    rdData;
    regSel_e rdSel;
  } csrStrobe_t;

endpackage

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output csrStrobe_t        strb
);

  regSel_e hitSel;

  always_comb begin
    if (busAddr == ADDR_W'(OFF_CTL))       hitSel = SEL_CTL;
    else if (busAddr == ADDR_W'(OFF_BAUD)) hitSel = SEL_BAUD;
    else if (busAddr == ADDR_W'(OFF_CFG))  hitSel = SEL_CFG;
    else if (busAddr == ADDR_W'(OFF_IRQ))  hitSel = SEL_IRQ;
    else if (busAddr == ADDR_W'(OFF_DATA)) hitSel = SEL_DATA;
    else                                   hitSel = SEL_NONE;
  end

  always_comb begin
    strb        = '0;
    strb.rdSel  = hitSel;
    strb.wrCtl  = busWr && (hitSel == SEL_CTL);
    strb.wrBaud = busWr && (hitSel == SEL_BAUD);
    strb.wrCfg  = busWr && (hitSel == SEL_CFG);
    strb.wrIrq  = busWr && (hitSel == SEL_IRQ);
    strb.wrData = busWr && (hitSel == SEL_DATA);
    strb.rdData = busRd && (hitSel == SEL_DATA);
  end

endmodule

// File: rtl/uart_csr_dp.sv
module uart_csr_dp
  import uart_csr_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strb,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [23:0]       ctlWord,
  output logic [BUS_W-1:0]  baudWord,
  output logic [THR_W-1:0]  rxThresh,
  output logic [THR_W-1:0]  txThresh,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              txPush,
  output logic [CHAR_W-1:0] txData,
  output logic              rxPop,
  output logic              irq,
  output logic              ovrSticky,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxNotEmpty,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxFrameErr,
  input  logic              rxParErr,
  input  logic              rxBreak,
  input  logic              rxOverrun
);

  localparam int          CFG_LO   = 8;
  localparam int          CFG_W    = 2 * THR_W;
  localparam logic [23:0] CTL_KEEP = ~((24'd1 << CTL_RST_RX) | (24'd1 << CTL_RST_TX) | (24'd1 << 15));

  logic [CFG_W-1:0]  cfgQ;
  logic [STAT_W-1:0] irqEnQ;
  logic [STAT_W-1:0] statusVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlWord   <= '0;
      baudWord  <= '0;
      cfgQ      <= '0;
      irqEnQ    <= '0;
      ovrSticky <= 1'b0;
      rxFifoRst <= 1'b0;
      txFifoRst <= 1'b0;
    end else begin
      if (strb.wrCtl)  ctlWord  <= busWdata[23:0] & CTL_KEEP;
      if (strb.wrBaud) baudWord <= busWdata;
      if (strb.wrCfg)  cfgQ     <= busWdata[CFG_LO +: CFG_W];
      if (strb.wrIrq)  irqEnQ   <= busWdata[STAT_W +: STAT_W];
      rxFifoRst <= strb.wrCtl && busWdata[CTL_RST_RX] && !rxFifoRst;
      txFifoRst <= strb.wrCtl && busWdata[CTL_RST_TX] && !txFifoRst;
      if (rxOverrun)
        ovrSticky <= 1'b1;
      else if (strb.wrIrq && !busWdata[ST_OVERRUN])
        ovrSticky <= 1'b0;
    end
  end

  assign rxThresh = cfgQ[THR_W-1:0];
  assign txThresh = cfgQ[CFG_W-1:THR_W];

  always_comb begin
    statusVec             = '0;
    statusVec[ST_TXEMPTY] = txEmpty;
    statusVec[ST_OVERRUN] = ovrSticky;
    statusVec[ST_RXAVAIL] = rxNotEmpty;
  end

  assign irq    = |(statusVec & irqEnQ);
  assign txPush = strb.wrData && !txFull;
  assign txData = busWdata[CHAR_W-1:0];
  assign rxPop  = strb.rdData && rxNotEmpty;

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      SEL_CTL:  busRdata[23:0] = ctlWord;
      SEL_BAUD: busRdata = baudWord;
      SEL_CFG:  busRdata[CFG_LO +: CFG_W] = cfgQ;
      SEL_IRQ:  busRdata[2*STAT_W-1:0] = {irqEnQ, statusVec};
      SEL_DATA: busRdata[CHAR_W+2:0] = {rxBreak, rxParErr, rxFrameErr, rxChar};
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic [4:0]        rxTimeout,
  output logic [3:0]        stopCode,
  output logic [1:0]        symSize,
  output logic              txBreak,
  output logic              rxParEven,
  output logic              rxParEn,
  output logic              txParEven,
  output logic              txParEn,
  output logic              loopback,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              baudEnable,
  output logic [BUS_W-1:0]  baudWord,
  output logic [THR_W-1:0]  rxThresh,
  output logic [THR_W-1:0]  txThresh,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              txPush,
  output logic [CHAR_W-1:0] txData,
  output logic              rxPop,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxNotEmpty,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxFrameErr,
  input  logic              rxParErr,
  input  logic              rxBreak,
  input  logic              rxOverrun
);

  csrStrobe_t  strb;
  logic [23:0] ctlWord;
  logic        ovrSticky;

  uart_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  uart_csr_dp #(.BUS_W(BUS_W), .CHAR_W(CHAR_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRdata(busRdata),
    .ctlWord(ctlWord), .baudWord(baudWord), .rxThresh(rxThresh), .txThresh(txThresh),
    .rxFifoRst(rxFifoRst), .txFifoRst(txFifoRst), .txPush(txPush), .txData(txData),
    .rxPop(rxPop), .irq(irq), .ovrSticky(ovrSticky), .txEmpty(txEmpty), .txFull(txFull),
    .rxNotEmpty(rxNotEmpty), .rxChar(rxChar), .rxFrameErr(rxFrameErr),
    .rxParErr(rxParErr), .rxBreak(rxBreak), .rxOverrun(rxOverrun)
  );

  assign rxTimeout  = ctlWord[4:0];
  assign stopCode   = ctlWord[11:8];
  assign symSize    = ctlWord[13:12];
  assign txBreak    = ctlWord[14];
  assign rxParEven  = ctlWord[16];
  assign rxParEn    = ctlWord[17];
  assign txParEven  = ctlWord[18];
  assign txParEn    = ctlWord[19];
  assign loopback   = ctlWord[20];
  assign rxEnable   = ctlWord[21];
  assign txEnable   = ctlWord[22];
  assign baudEnable = ctlWord[23];

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk (
  input logic clk,
  input logic rstN,
  input logic txPush,
  input logic txFull,
  input logic rxPop,
  input logic rxNotEmpty,
  input logic txEmpty,
  input logic rxFifoRst,
  input logic txFifoRst,
  input logic rxOverrun,
  input logic ovrSticky,
  input logic wrIrq,
  input logic irq
);

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rstN) txPush |-> !txFull);

  // R7
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN) rxPop |-> rxNotEmpty);

  // R3
  rx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) rxFifoRst |=> !rxFifoRst);

  // R3
  tx_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) txFifoRst |=> !txFifoRst);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN) rxOverrun |=> ovrSticky);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (ovrSticky && !wrIrq) |=> ovrSticky);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN) irq |-> (txEmpty || rxNotEmpty || ovrSticky));

endmodule

bind uart_csr_block uart_csr_chk u_chk (
  .clk(clk), .rstN(rstN), .txPush(txPush), .txFull(txFull), .rxPop(rxPop),
  .rxNotEmpty(rxNotEmpty), .txEmpty(txEmpty), .rxFifoRst(rxFifoRst),
  .txFifoRst(txFifoRst), .rxOverrun(rxOverrun), .ovrSticky(ovrSticky),
  .wrIrq(strb.wrIrq), .irq(irq)
);

// File: tb/uart_csr_block_bench.sv
`timescale 1ns/1ps
module uart_csr_block_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic [4:0]  rxTimeout;
  logic [3:0]  stopCode;
  logic [1:0]  symSize;
  logic        txBreak, rxParEven, rxParEn, txParEven, txParEn, loopback;
  logic        rxEnable, txEnable, baudEnable;
  logic [31:0] baudWord;
  logic [3:0]  rxThresh, txThresh;
  logic        rxFifoRst, txFifoRst, txPush, rxPop;
  logic [7:0]  txData;
  logic        txEmpty = 1'b0, txFull = 1'b0, rxNotEmpty = 1'b0;
  logic [7:0]  rxChar = '0;
  logic        rxFrameErr = 1'b0, rxParErr = 1'b0, rxBreak = 1'b0, rxOverrun = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_csr_block u_uart_csr_block (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .rxTimeout(rxTimeout),
    .stopCode(stopCode), .symSize(symSize), .txBreak(txBreak), .rxParEven(rxParEven),
    .rxParEn(rxParEn), .txParEven(txParEven), .txParEn(txParEn), .loopback(loopback),
    .rxEnable(rxEnable), .txEnable(txEnable), .baudEnable(baudEnable),
    .baudWord(baudWord), .rxThresh(rxThresh), .txThresh(txThresh),
    .rxFifoRst(rxFifoRst), .txFifoRst(txFifoRst), .txPush(txPush), .txData(txData),
    .rxPop(rxPop), .txEmpty(txEmpty), .txFull(txFull), .rxNotEmpty(rxNotEmpty),
    .rxChar(rxChar), .rxFrameErr(rxFrameErr), .rxParErr(rxParErr),
    .rxBreak(rxBreak), .rxOverrun(rxOverrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst pulses", {30'd0, rxFifoRst, txFifoRst}, 32'd0);
    busRead(5'h00, d); check("R1 ctl", d, 32'd0);
    busRead(5'h04, d); check("R1 baud", d, 32'd0);
    busRead(5'h10, d); check("R1 irq reg", d, 32'd0);
  endtask

  task automatic testCtl();
    logic [31:0] d;
    busWrite(5'h00, 32'hFFFF_FF3F);
    busRead(5'h00, d); check("R2 all ones", d, 32'h00FF_7F3F);
    busWrite(5'h00, 32'h00E5_3705);
    busRead(5'h00, d); check("R2 typical", d, 32'h00E5_3705);
    check("R2 fields", {rxTimeout, stopCode, symSize, txBreak, rxParEven, rxParEn,
          txParEven, txParEn, loopback, rxEnable, txEnable, baudEnable},
          {5'd5, 4'd7, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1});
  endtask

  task automatic testFifoReset();
    logic [31:0] d;
    busWrite(5'h00, 32'h00E5_3745);
    check("R3 rx pulse", {31'd0, rxFifoRst}, 32'd1);
    check("R3 tx quiet", {31'd0, txFifoRst}, 32'd0);
    @(negedge clk);
    check("R3 rx clear", {31'd0, rxFifoRst}, 32'd0);
    busRead(5'h00, d); check("R3 readback", d, 32'h00E5_3705);
    busWrite(5'h00, 32'h00E5_3785);
    check("R3 tx pulse", {30'd0, rxFifoRst, txFifoRst}, 32'd1);
    @(negedge clk);
    check("R3 tx clear", {31'd0, txFifoRst}, 32'd0);
  endtask

  task automatic testBaudCfg();
    logic [31:0] d;
    busWrite(5'h04, 32'hDEAD_BEEF);
    busRead(5'h04, d); check("R4 baud read", d, 32'hDEAD_BEEF);
    check("R4 baud port", baudWord, 32'hDEAD_BEEF);
    busWrite(5'h08, 32'hFFFF_A5FF);
    busRead(5'h08, d); check("R5 cfg read", d, 32'h0000_A500);
    check("R5 thresholds", {24'd0, txThresh, rxThresh}, 32'h0000_00A5);
  endtask

  task automatic testTx();
    @(negedge clk);
    busAddr = 5'h14; busWdata = 32'h0000_01A5; busWr = 1'b1; txFull = 1'b0;
    #1 check("R6 push", {23'd0, txPush, txData}, {23'd0, 1'b1, 8'hA5});
    @(negedge clk);
    txFull = 1'b1; busWdata = 32'h0000_003C;
    #1 check("R6 drop when full", {31'd0, txPush}, 32'd0);
    @(negedge clk);
    busWr = 1'b0; txFull = 1'b0;
  endtask

  task automatic testRx();
    logic [31:0] d;
    rxChar = 8'h3C; rxFrameErr = 1'b1; rxParErr = 1'b0; rxBreak = 1'b1; rxNotEmpty = 1'b1;
    @(negedge clk);
    busAddr = 5'h14; busRd = 1'b1;
    #1 d = busRdata;
    check("R7 tagged char", d, 32'h0000_053C);
    check("R7 pop", {31'd0, rxPop}, 32'd1);
    @(negedge clk);
    rxNotEmpty = 1'b0; rxFrameErr = 1'b0; rxBreak = 1'b0; rxParErr = 1'b1;
    #1 check("R7 no pop when empty", {31'd0, rxPop}, 32'd0);
    check("R7 parity tag", busRdata, 32'h0000_023C);
    @(negedge clk);
    busRd = 1'b0; rxParErr = 1'b0;
  endtask

  task automatic testStatus();
    logic [31:0] d;
    txEmpty = 1'b1; rxNotEmpty = 1'b1;
    @(negedge clk); rxOverrun = 1'b1;
    @(negedge clk); rxOverrun = 1'b0;
    busRead(5'h10, d); check("R8 status", d, 32'h0000_08A0);
    check("R10 no enables", {31'd0, irq}, 32'd0);
    busWrite(5'h10, 32'h0800_0080);
    busRead(5'h10, d); check("R9 keep ovr, load mask", d, 32'h0800_08A0);
    check("R10 rx avail irq", {31'd0, irq}, 32'd1);
    @(negedge clk); rxNotEmpty = 1'b0;
    #1 check("R10 irq drops", {31'd0, irq}, 32'd0);
    busWrite(5'h10, 32'h0080_0080);
    check("R10 ovr irq", {31'd0, irq}, 32'd1);
    busWrite(5'h10, 32'h0080_0000);
    busRead(5'h10, d); check("R9 write zero clears", d, 32'h0080_0020);
    check("R10 cleared irq", {31'd0, irq}, 32'd0);
    txEmpty = 1'b0;
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(5'h0C, 32'hFFFF_FFFF);
    busWrite(5'h18, 32'hFFFF_FFFF);
    busRead(5'h0C, d); check("R11 read 0x0C", d, 32'd0);
    busRead(5'h18, d); check("R11 read 0x18", d, 32'd0);
    busRead(5'h04, d); check("R11 baud kept", d, 32'hDEAD_BEEF);
    busRead(5'h08, d); check("R11 cfg kept", d, 32'h0000_A500);
    busRead(5'h00, d); check("R11 ctl kept", d, 32'h00E5_3705);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCtl();
    testFifoReset();
    testBaudCfg();
    testTx();
    testRx();
    testStatus();
    testUnmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule